// File: doc/BRIEF.md
# Output-Stationary Systolic MAC Array

This block is a grid of multiply-accumulate cells that computes a signed integer matrix product C = A x B, where A is ROWS x DEPTH and B is DEPTH x COLS. Each cell owns one element of C. The cell keeps its running sum in place and passes its two operands on to its neighbours through registers. A operands enter on the west edge, one lane per row, and move east. B operands enter on the north edge, one lane per column, and move south. A single registered valid bit travels with the operands. A cell adds a product only when the operands it sees from both directions are valid.

An external skew stage feeds the lanes. It asserts `start`, usually together with `clear`, in one cycle. In each of the following cycles it presents one diagonal of the operands. A completion controller counts a fixed number of cycles from `start` and then raises `done` for one cycle. In that cycle every accumulator holds its final dot product. The accumulators drive the flat `results` bus directly and hold their values until they are cleared.

Top module: `os_mac_array`

## Requirements
- R1: Cycle 0 is the cycle after the one in which `start` is high. From then on, west lane r (bits [8r+7:8r]) carries A[r][k] with its valid high in cycle r+k, and north lane c (bits [8c+7:8c]) carries B[k][c] with its valid high in cycle c+k. Under that timing, result slice (r*COLS+c), 32 bits wide at bit (r*COLS+c)*32, accumulates the sum over k of A[r][k]*B[k][c].
- R2: Operands are two's-complement 8-bit values and accumulators are two's-complement 32-bit values. The extremes -128 and 127 multiply exactly. When `clear` is not given, a new product set adds onto the previous sums, wrapping modulo 2^32 without saturation.
- R3: A cell changes its accumulator and its forwarded operands only in a cycle where its valid input is high. When every lane valid is low, the results do not change, whatever is on the data lanes.
- R4: `clear` zeroes every accumulator on the next edge. It overrides a product that arrives on the same edge, so that product is lost.
- R5: A cell's valid input is the AND of a row validity and a column validity. The row validity comes from the west lane valid in column 0 and from the west neighbour's registered valid elsewhere. The column validity comes from the north lane valid in row 0 and from the north neighbour's registered valid elsewhere. Driving only the west valids, or only the north valids, accumulates nothing.
- R6: `done` is high for exactly one cycle. It rises ROWS+COLS+DEPTH-2 clock edges after the edge that sampled `start`.
- R7: The same RTL gives correct products and correct `done` timing at 8x8 with DEPTH 8 and at 4x4 with DEPTH 4, with only parameters changed.
- R8: For random signed operands, every result equals the integer matrix product computed in software, bit for bit, in the cycle `done` is high.
- R9: After `done`, with all lane valids low, the results stay unchanged until the next `clear`.
- R10: The synchronous active-high `rst` drives every result to zero and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins the completion count |
| clear | input | 1 | Zeroes all accumulators; takes priority over valid data |
| west_data | input | ROWS*8 | Skewed A operands, one signed byte per row |
| west_valid | input | ROWS | Per-row validity of west_data |
| north_data | input | COLS*8 | Skewed B operands, one signed byte per column |
| north_valid | input | COLS | Per-column validity of north_data |
| results | output | ROWS*COLS*32 | Accumulators, row-major, 32-bit signed each |
| done | output | 1 | One-cycle pulse when all results are final |

## Verification
The hardest case to reach from the ports is an edge where `clear` and a valid operand pair meet in the same cell. The bench makes this happen by holding `clear` for the edge that follows `start` as well, which is the edge where the corner cell receives its first operands. It then expects the corner result to lack exactly that first product while every other cell is unaffected. The position-dependent validity rule is tested by driving only the row lanes or only the column lanes with full data patterns. Garbage on the data lanes outside the valid windows checks that padding never enters a sum. Both grid sizes run in lockstep from the same control signals, so each run compares two configurations.

// File: rtl/os_mac_pkg.sv
package os_mac_pkg;
  localparam int OP_W  = 8;
  localparam int ACC_W = 32;

  typedef logic signed [OP_W-1:0]   operand_t;
  typedef logic signed [2*OP_W-1:0] product_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // Edges from the start edge until the last cell's final update is visible.
  function automatic int fill_latency(int rows, int cols, int depth);
    return rows + cols + depth - 2;
  endfunction
endpackage

// File: rtl/os_mac_cell.sv
module os_mac_cell
  import os_mac_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clear,
  input  operand_t a_in,
  input  operand_t b_in,
  input  logic     valid_in,
  output operand_t a_out,
  output operand_t b_out,
  output logic     valid_out,
  output acc_t     acc
);
  product_t prod;
  assign prod = a_in * b_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out     <= '0;
      b_out     <= '0;
      valid_out <= 1'b0;
      acc       <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        a_out <= a_in;
        b_out <= b_in;
        acc   <= acc + acc_t'(prod);
      end
      // clear wins over an arriving product
      if (clear) acc <= '0;
    end
  end
endmodule

// File: rtl/os_mac_done_ctrl.sv
module os_mac_done_ctrl #(
  parameter int LATENCY = 22
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(LATENCY + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(LATENCY - 1)) begin
          done <= 1'b1;
          busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/os_mac_array.sv
module os_mac_array
  import os_mac_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        clear,
  input  logic [ROWS*OP_W-1:0]        west_data,
  input  logic [ROWS-1:0]             west_valid,
  input  logic [COLS*OP_W-1:0]        north_data,
  input  logic [COLS-1:0]             north_valid,
  output logic [ROWS*COLS*ACC_W-1:0]  results,
  output logic                        done
);
  localparam int LATENCY = fill_latency(ROWS, COLS, DEPTH);

  operand_t a_q   [ROWS][COLS];
  operand_t b_q   [ROWS][COLS];
  logic     v_q   [ROWS][COLS];
  acc_t     acc_q [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      operand_t a_src, b_src;
      logic     v_in;

      if (c == 0) begin : g_west
        assign a_src = west_data[r*OP_W +: OP_W];
      end else begin : g_west_nb
        assign a_src = a_q[r][c-1];
      end

      if (r == 0) begin : g_north
        assign b_src = north_data[c*OP_W +: OP_W];
      end else begin : g_north_nb
        assign b_src = b_q[r-1][c];
      end

      // validity of the two incoming operands, by grid position
      if (r == 0 && c == 0) begin : g_v_corner
        assign v_in = west_valid[r] & north_valid[c];
      end else if (r == 0) begin : g_v_top
        assign v_in = v_q[r][c-1] & north_valid[c];
      end else if (c == 0) begin : g_v_left
        assign v_in = west_valid[r] & v_q[r-1][c];
      end else begin : g_v_inner
        assign v_in = v_q[r][c-1] & v_q[r-1][c];
      end

      os_mac_cell u_cell (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .a_in      (a_src),
        .b_in      (b_src),
        .valid_in  (v_in),
        .a_out     (a_q[r][c]),
        .b_out     (b_q[r][c]),
        .valid_out (v_q[r][c]),
        .acc       (acc_q[r][c])
      );

      assign results[(r*COLS+c)*ACC_W +: ACC_W] = acc_q[r][c];
    end
  end

  // operands leaving the far edges have no consumer
  logic [ROWS-1:0] unused_east;
  logic [COLS-1:0] unused_south;
  logic            unused_corner_v;
  for (genvar r = 0; r < ROWS; r++) begin : g_east_sink
    assign unused_east[r] = ^a_q[r][COLS-1];
  end
  for (genvar c = 0; c < COLS; c++) begin : g_south_sink
    assign unused_south[c] = ^b_q[ROWS-1][c];
  end
  assign unused_corner_v = v_q[ROWS-1][COLS-1];

  os_mac_done_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .done  (done)
  );
endmodule

// File: rtl/os_mac_array_chk.sv
module os_mac_array_chk
  import os_mac_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       start,
  input logic                       clear,
  input logic [ROWS-1:0]            west_valid,
  input logic [COLS-1:0]            north_valid,
  input logic [ROWS*COLS*ACC_W-1:0] results,
  input logic                       done
);
  localparam int LATENCY = fill_latency(ROWS, COLS, DEPTH);
  localparam int SW      = 16;

  logic [SW-1:0] since_start;
  logic          armed;
  logic          held;
  logic          lanes_idle;

  assign lanes_idle = !(|west_valid) && !(|north_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_start <= '0;
      armed       <= 1'b0;
      held        <= 1'b0;
    end else begin
      if (start) begin
        since_start <= '0;
        armed       <= 1'b1;
      end else if (since_start != '1) begin
        since_start <= since_start + 1'b1;
      end
      if (clear || start || !lanes_idle) held <= 1'b0;
      else if (done)                     held <= 1'b1;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clear |=> (results == '0)); // R4

  AST_CORNER_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    (!clear && !(west_valid[0] && north_valid[0])) |=> $stable(results[ACC_W-1:0])); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (rst)
    done |-> (armed && since_start == SW'(LATENCY))); // R6

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (rst)
    (held && !clear && !start && lanes_idle) |=> $stable(results)); // R9
endmodule

bind os_mac_array os_mac_array_chk #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_os_mac_array.sv
module test_os_mac_array;
  localparam int CLK_PERIOD = 10;
  localparam int BIG = 8;
  localparam int SMALL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic clear = 1'b0;

  logic [BIG*8-1:0]       w8, n8;
  logic [BIG-1:0]         wv8, nv8;
  logic [BIG*BIG*32-1:0]  res8;
  logic                   done8;
  logic [SMALL*8-1:0]     w4, n4;
  logic [SMALL-1:0]       wv4, nv4;
  logic [SMALL*SMALL*32-1:0] res4;
  logic                   done4;

  always #(CLK_PERIOD/2) clk = ~clk;

  os_mac_array #(.ROWS(BIG), .COLS(BIG), .DEPTH(BIG)) i_os_mac_array (
    .clk(clk), .rst(rst), .start(start), .clear(clear),
    .west_data(w8), .west_valid(wv8), .north_data(n8), .north_valid(nv8),
    .results(res8), .done(done8));

  os_mac_array #(.ROWS(SMALL), .COLS(SMALL), .DEPTH(SMALL)) i_os_mac_array_small (
    .clk(clk), .rst(rst), .start(start), .clear(clear),
    .west_data(w4), .west_valid(wv4), .north_data(n4), .north_valid(nv4),
    .results(res4), .done(done4));

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int sz [2] = '{BIG, SMALL};
  logic signed [7:0] am [2][8][8];
  logic signed [7:0] bm [2][8][8];
  int exp_c [2][8][8];

  function automatic int res(int i, int r, int c);
    if (i == 0) return int'(res8[(r*BIG+c)*32 +: 32]);
    return int'(res4[(r*SMALL+c)*32 +: 32]);
  endfunction

  function automatic logic [7:0] pick(int pat, bit is_b);
    logic [7:0] v;
    v = 8'($urandom);
    case (pat)
      1: return 8'h80;
      2: return 8'h7F;
      3: return is_b ? 8'h7F : 8'h80;
      4: return ($urandom % 2) ? v : 8'h00;
      default: return v;
    endcase
  endfunction

  task automatic fill(int pat);
    for (int i = 0; i < 2; i++)
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++) begin
          am[i][r][c] = pick(pat, 1'b0);
          bm[i][r][c] = pick(pat, 1'b1);
        end
  endtask

  task automatic idle_lanes();
    w8 = '0; n8 = '0; wv8 = '0; nv8 = '0;
    w4 = '0; n4 = '0; wv4 = '0; nv4 = '0;
  endtask

  // mode: 0 normal, 1 west valids only, 2 north valids only,
  //       3 clear also on first data edge, 5 all valids low
  task automatic drive(int t, int mode);
    for (int i = 0; i < 2; i++)
      for (int l = 0; l < sz[i]; l++) begin
        logic wv, nv;
        logic [7:0] wd, nd;
        wv = (t >= l) && (t < l + sz[i]);
        nv = wv;
        wd = wv ? am[i][l][t-l] : 8'h5A;
        nd = nv ? bm[i][t-l][l] : 8'hA5;
        if (mode == 2 || mode == 5) wv = 1'b0;
        if (mode == 1 || mode == 5) nv = 1'b0;
        if (i == 0) begin
          w8[l*8 +: 8] = wd; n8[l*8 +: 8] = nd; wv8[l] = wv; nv8[l] = nv;
        end else begin
          w4[l*8 +: 8] = wd; n4[l*8 +: 8] = nd; wv4[l] = wv; nv4[l] = nv;
        end
      end
  endtask

  task automatic cmp_all(int i, string tag);
    int br, bc;
    br = -1; bc = -1;
    total++;
    for (int r = 0; r < sz[i]; r++)
      for (int c = 0; c < sz[i]; c++)
        if (br < 0 && res(i, r, c) != exp_c[i][r][c]) begin br = r; bc = c; end
    if (br >= 0) begin
      bad++;
      $display("FAIL %s%s cell(%0d,%0d) actual=%0d expected=%0d", tag,
               (i == 1) ? " R7 4x4" : " 8x8", br, bc, res(i, br, bc), exp_c[i][br][bc]);
    end
  endtask

  task automatic set_zero_exp();
    for (int i = 0; i < 2; i++)
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++) exp_c[i][r][c] = 0;
  endtask

  task automatic run(int pat, int mode, bit clr, string tag);
    int dcnt [2];
    int dat [2];
    int lat;
    fill(pat);
    if (clr || mode == 3) set_zero_exp();
    if (mode == 0 || mode == 3)
      for (int i = 0; i < 2; i++)
        for (int r = 0; r < sz[i]; r++)
          for (int c = 0; c < sz[i]; c++)
            for (int k = 0; k < sz[i]; k++)
              if (!(mode == 3 && r == 0 && c == 0 && k == 0))
                exp_c[i][r][c] += int'(am[i][r][k]) * int'(bm[i][k][c]);
    dcnt[0] = 0; dcnt[1] = 0; dat[0] = -1; dat[1] = -1;
    @(negedge clk);
    start = 1'b1; clear = clr || (mode == 3); idle_lanes();
    for (int j = 0; j <= 26; j++) begin
      @(negedge clk);
      if (j == 0) begin start = 1'b0; clear = (mode == 3); end
      if (j == 1) clear = 1'b0;
      if (done8) begin dcnt[0]++; dat[0] = j; cmp_all(0, {tag, " at done"}); end
      if (done4) begin dcnt[1]++; dat[1] = j; cmp_all(1, {tag, " at done"}); end
      drive(j, mode);
    end
    idle_lanes();
    for (int i = 0; i < 2; i++) begin
      lat = 3 * sz[i] - 2;
      total++;
      if (dcnt[i] != 1 || dat[i] != lat) begin
        bad++;
        $display("FAIL R6 inst=%0d done count=%0d at edge %0d expected 1 at edge %0d",
                 i, dcnt[i], dat[i], lat);
      end
    end
    repeat (3) @(negedge clk);
    cmp_all(0, "R9 after idle");
    cmp_all(1, "R9 after idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_lanes();
    set_zero_exp();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    cmp_all(0, "R10 reset");
    cmp_all(1, "R10 reset");
    total++;
    if (done8 || done4) begin bad++; $display("FAIL R10 done actual=1 expected=0"); end

    run(1, 0, 1'b1, "R2 min*min");
    run(2, 0, 1'b0, "R2 accumulate");
    run(3, 0, 1'b1, "R2 min*max");
    run(0, 1, 1'b0, "R5 west only");
    run(0, 2, 1'b0, "R5 north only");
    run(0, 5, 1'b0, "R3 no valid");
    run(4, 3, 1'b0, "R4 clear priority");
    run(4, 0, 1'b1, "R1 sparse");
    for (int n = 0; n < 20; n++) run(0, 0, 1'b1, "R8 random");

    // R9: long idle hold, then clear alone (R4)
    repeat (40) @(negedge clk);
    cmp_all(0, "R9 long hold");
    cmp_all(1, "R9 long hold");
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    set_zero_exp();
    cmp_all(0, "R4 clear alone");
    cmp_all(1, "R4 clear alone");

    // R10: reset after data
    run(0, 0, 1'b1, "R8 random");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    set_zero_exp();
    cmp_all(0, "R10 reset after data");
    cmp_all(1, "R10 reset after data");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule